// File: doc/BRIEF.md
# Cascadable Serial-In Latched-Output Register

This block turns a slow four-wire serial stream into a wide parallel word that drives output loads such as indicator lamps. A controller presents one bit at a time on a data line and pulses a serial clock. Each rising edge of that clock pushes the bit into an internal shift chain. A separate output latch holds the word shown on the parallel pins. An active-low load line copies the chain into the latch. An active-low blank line forces the latch and the pins to zero. The last stage of the chain leaves the block on a serial output, so the data input of a second copy can take it and two devices form one longer chain.

The model is synchronous to a fast system clock. The serial clock, data, load and blank lines are sampled as ordinary synchronous inputs, and a rising edge of the serial clock is found by comparing it with its value one system cycle earlier. While load is held low the latch takes the chain contents on every system clock, in the same cycle as each shift. The outputs therefore track the chain, and a controller that does not want this must keep the serial clock still during a load. Blank clears only the latch and has priority over load. The shift chain is never reset by blank.

Top module: `serial_latch_out`

## Requirements
- R1: After reset every parallel output and the serial output are 0, and the shift chain is all zeros.
- R2: The chain moves only on a rising edge of the serial clock, that is a system cycle where it is high after being low the cycle before. On that edge the data input enters the position-1 stage (bit 0), and every stage k moves to stage k+1. A serial clock held steady high or low moves nothing.
- R3: After 20 rising edges the first bit shifted in sits in stage 20, which drives `par_out[19]`. The most recent bit sits in stage 1 (`par_out[0]`), and `ser_dout` shows stage 20.
- R4: With load high and blank high, the parallel outputs keep their value while the chain shifts.
- R5: In the system cycle where load is sampled low with blank high, the latch takes the chain contents, including a shift made in that same cycle. They appear on `par_out` after that clock edge.
- R6: While load stays low and blank stays high, every shift is seen at once on `par_out`, which keeps equal to the chain.
- R7: While blank is low, `par_out` is all zeros without waiting for a clock edge, and the latch is cleared. After blank returns high with load high, the outputs stay zero.
- R8: Blank does not touch the shift chain. Bits shifted before or during blank are still present when a later load takes place.
- R9: Blank has priority over load. With both low the outputs remain zero, and nothing is held for after blank is released.
- R10: `ser_dout` follows stage 20 whatever the load and blank levels are. Feeding it into a second device's `ser_din` with shared clock, load and blank lines makes one 40-bit chain.
- R11: A serial clock whose high and low phases each last at least two system cycles is followed without a missed or doubled edge. With a 250 MHz system clock this covers a 5 MHz serial clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ser_clk | input | 1 | Serial clock, sampled by `clk`; a rising edge shifts |
| ser_din | input | 1 | Serial data into stage 1 |
| load_n | input | 1 | Active-low load: latch follows the chain while low |
| blank_n | input | 1 | Active-low blank: clears the latch and zeroes the outputs |
| par_out | output | WIDTH | Parallel outputs, bit 0 is stage 1 |
| ser_dout | output | 1 | Last chain stage, for cascading |

## Verification
The assertions assume that all four control and data lines are synchronous to the system clock and that the serial clock is low while reset is applied, so the first edge seen after reset is a real one. The stimulus changes every input half a system cycle away from the sampling edge. It holds each serial clock phase for two system cycles and keeps the serial clock low through reset. It mixes random data bits and random load and blank levels with directed cases for bit order, clear priority and a steady serial clock.

// File: rtl/serial_latch_out_pkg.sv
package serial_latch_out_pkg;
  localparam int unsigned DEF_WIDTH = 20;

  typedef enum logic [1:0] {
    LA_HOLD   = 2'd0,
    LA_FOLLOW = 2'd1,
    LA_CLEAR  = 2'd2
  } latch_act_e;
endpackage

// File: rtl/slo_edge_detect.sv
module slo_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sig_in;
    rise   = sig_in & ~prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/slo_shift_chain.sv
module slo_shift_chain #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             din,
  output logic [WIDTH-1:0] chain_q,
  output logic [WIDTH-1:0] chain_d
);
  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[WIDTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chain_q <= '0;
    else if (shift_en) chain_q <= chain_d;
  end
endmodule

// File: rtl/slo_out_latch.sv
module slo_out_latch
  import serial_latch_out_pkg::*;
#(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  latch_act_e       act,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_d;
  logic             q_en;

  always_comb begin
    q_d  = q;
    q_en = 1'b0;
    case (act)
      LA_CLEAR:  begin q_d = '0; q_en = 1'b1; end
      LA_FOLLOW: begin q_d = d;  q_en = 1'b1; end
      default:   begin q_d = q;  q_en = 1'b0; end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end
endmodule

// File: rtl/serial_latch_out.sv
module serial_latch_out
  import serial_latch_out_pkg::*;
#(
  parameter int unsigned WIDTH = DEF_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_din,
  input  logic             load_n,
  input  logic             blank_n,
  output logic [WIDTH-1:0] par_out,
  output logic             ser_dout
);
  localparam int unsigned LAST = WIDTH - 1;

  logic             shift_en;
  logic [WIDTH-1:0] shift_q;
  logic [WIDTH-1:0] shift_d;
  logic [WIDTH-1:0] latch_q;
  latch_act_e       act;

  slo_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in (ser_clk),
    .rise   (shift_en)
  );

  slo_shift_chain #(.WIDTH(WIDTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (ser_din),
    .chain_q  (shift_q),
    .chain_d  (shift_d)
  );

  // Blank outranks load (R9); load low makes the latch transparent (R5, R6).
  always_comb begin
    if (!blank_n)     act = LA_CLEAR;
    else if (!load_n) act = LA_FOLLOW;
    else              act = LA_HOLD;
  end

  slo_out_latch #(.WIDTH(WIDTH)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .d     (shift_d),
    .q     (latch_q)
  );

  // Blank zeroes the pins without waiting for an edge (R7).
  always_comb begin
    par_out  = blank_n ? latch_q : '0;
    ser_dout = shift_q[LAST];
  end
endmodule

// File: rtl/serial_latch_out_chk.sv
module serial_latch_out_chk #(
  parameter int unsigned WIDTH = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ser_din,
  input logic             load_n,
  input logic             blank_n,
  input logic             shift_en,
  input logic [WIDTH-1:0] shift_q,
  input logic [WIDTH-1:0] latch_q,
  input logic             ser_dout
);
  // R2: an edge pushes the data bit in at stage 1
  a_r2_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (shift_q == {$past(shift_q[WIDTH-2:0]), $past(ser_din)}));

  // R2: no edge, no movement
  a_r2_no_edge_still: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(shift_q));

  // R4: load and blank both high keep the latch
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && load_n) |=> $stable(latch_q));

  // R5 / R6: load low makes the latch equal the chain after the edge
  a_r5_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (blank_n && !load_n) |=> (latch_q == shift_q));

  // R7 / R9: blank clears the latch whatever load does
  a_r9_blank_wins: assert property (@(posedge clk) disable iff (!rst_n)
    !blank_n |=> (latch_q == '0));

  // R10: serial output moves only with a shift, whatever load and blank do
  a_r10_sdo_still: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(ser_dout));
endmodule

bind serial_latch_out serial_latch_out_chk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ser_din  (ser_din),
  .load_n   (load_n),
  .blank_n  (blank_n),
  .shift_en (shift_en),
  .shift_q  (shift_q),
  .latch_q  (latch_q),
  .ser_dout (ser_dout)
);

// File: tb/tb_serial_latch_out.sv
module tb_serial_latch_out;
  localparam int W = 20;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         ser_clk = 1'b0;
  logic         ser_din = 1'b0;
  logic         load_n = 1'b1;
  logic         blank_n = 1'b1;
  logic [W-1:0] par_a;
  logic [W-1:0] par_b;
  logic         sdo_a;
  logic         sdo_b;

  logic [W-1:0] m_a, m_b, l_a, l_b;
  int           n_cmp = 0;
  int           n_bad = 0;
  bit           done  = 0;

  always #2 clk = ~clk;

  serial_latch_out #(.WIDTH(W)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .load_n(load_n), .blank_n(blank_n), .par_out(par_a), .ser_dout(sdo_a)
  );

  serial_latch_out #(.WIDTH(W)) u_next (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(sdo_a),
    .load_n(load_n), .blank_n(blank_n), .par_out(par_b), .ser_dout(sdo_b)
  );

  function automatic logic [W-1:0] exp_par(logic [W-1:0] l, logic bl);
    return bl ? l : '0;
  endfunction

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_latch();
    if (!blank_n) begin l_a = '0; l_b = '0; end
    else if (!load_n) begin l_a = m_a; l_b = m_b; end
  endtask

  task automatic check_all(string req);
    chk(req, par_a, exp_par(l_a, blank_n));
    chk(req, par_b, exp_par(l_b, blank_n));
    chk(req, W'(sdo_a), W'(m_a[W-1]));
    chk(req, W'(sdo_b), W'(m_b[W-1]));
  endtask

  // One serial bit: two system cycles low, two high (R11 timing)
  task automatic send_bit(logic b);
    @(negedge clk); ser_din = b; ser_clk = 1'b0;
    @(negedge clk);
    @(negedge clk); ser_clk = 1'b1;
    @(negedge clk);
    m_b = {m_b[W-2:0], m_a[W-1]};
    m_a = {m_a[W-2:0], b};
    model_latch();
    @(negedge clk);
  endtask

  task automatic set_ctrl(logic ld, logic bl);
    @(negedge clk); load_n = ld; blank_n = bl;
    @(negedge clk);
    model_latch();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    m_a = '0; m_b = '0; l_a = '0; l_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");

    // R3: first bit lands in stage 20, R4 outputs hold while load high
    send_bit(1'b1);
    for (int i = 0; i < W-1; i++) begin
      send_bit(1'b0);
      check_all("R4 hold while shifting");
    end
    chk("R3 ser_dout is stage 20", W'(sdo_a), W'(1));
    set_ctrl(1'b0, 1'b1);
    chk("R3 first bit on par_out[19]", par_a, 20'h80000);
    set_ctrl(1'b1, 1'b1);

    // R10: 40-bit chain into two devices, common load
    for (int i = 0; i < 2*W; i++) begin
      send_bit(1'($urandom));
      check_all("R10 cascade shifting");
    end
    set_ctrl(1'b0, 1'b1);
    check_all("R5 load both devices");
    set_ctrl(1'b1, 1'b1);

    // R6: transparent while load low
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 8; i++) begin
      send_bit(1'($urandom));
      check_all("R6 follow while load low");
    end

    // R2: serial clock held steady high for many cycles
    @(negedge clk); ser_clk = 1'b1; ser_din = ~ser_din;
    repeat (6) @(negedge clk);
    check_all("R2 steady clock no shift");
    @(negedge clk); ser_clk = 1'b0;
    repeat (4) @(negedge clk);
    check_all("R2 falling edge no shift");
    set_ctrl(1'b1, 1'b1);

    // R7: blank zeroes before any clock edge
    @(negedge clk); blank_n = 1'b0;
    #0.5;
    chk("R7 blank immediate", par_a, '0);
    @(negedge clk); model_latch();
    check_all("R7 blank");
    // R8: shifting during blank still moves the chain
    for (int i = 0; i < 5; i++) begin
      send_bit(1'($urandom));
      check_all("R8 shift during blank");
    end
    // R9: load low under blank does nothing
    set_ctrl(1'b0, 1'b0);
    check_all("R9 blank over load");
    set_ctrl(1'b1, 1'b1);
    check_all("R9 nothing held after blank");
    chk("R7 stays zero after blank", par_a, '0);
    set_ctrl(1'b0, 1'b1);
    check_all("R8 chain kept through blank");
    set_ctrl(1'b1, 1'b1);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      int unsigned r = $urandom_range(0, 9);
      if (r < 6) send_bit(1'($urandom));
      else set_ctrl(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 4) != 0));
      check_all("R5 R6 R7 R10 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule